// File: doc/BRIEF.md
# Receive Command Detector and Descrambler

This block sits behind the symbol decoder of a 25.6 Mbit/s cell link receiver. Each cycle it may take one decoded nibble. A tag on the nibble says whether it is the escape symbol or an ordinary 4-bit value. The block pairs an escape with the nibble that follows it and treats the pair as a command. It keeps a local 10-bit pseudo-random generator in step with the far-end scrambler and strips the scrambling from the data nibbles. It then packs the nibbles into bytes, high half first, and delivers the 53 bytes of each cell with strobes that mark the first and the last byte.

Three commands are recognised. Escape-escape starts a cell and reloads the generator to all ones. This is the only event that locks the descrambler to the far end. Escape-'4' starts a cell and leaves the generator running. Escape-'8' is an 8 kHz timing marker. It may be spliced between any two bytes of a cell, and the cell then resumes with its byte alignment and generator phase intact. Any other code after an escape is reported as an error, and the cell in progress is dropped. If a new start-of-cell command arrives before a cell is complete, the partial cell is abandoned and reported as short.

Top module: `rx_cmd_descrambler`

## Requirements
- R1: After reset every output strobe is low. No byte is delivered, and escape-'4' starts nothing, until the first escape-escape has been seen.
- R2: An escape-escape starts a cell and reloads the generator to all ones, so the first data nibble after it is XORed with 1111.
- R3: The generator follows x^10 + x^7 + 1 and moves four bit positions for every valid nibble, command nibbles included. With X(t) the newest bit, data bits 3..0 are XORed with X(t-3), X(t-2), X(t-1), X(t). Command nibbles are not XORed.
- R4: Bytes are formed high nibble first. A byte appears one cycle after its low nibble, with out_first on byte 0 and out_last on byte 52. Data after the 53rd byte is discarded until the next start-of-cell.
- R5: Escape followed by data code 0100 starts a new cell and leaves the generator running.
- R6: Escape followed by data code 1000 pulses marker for one cycle, one cycle after the code nibble. A cell in progress continues with no lost byte and no generator slip.
- R7: Every escape nibble whose preceding valid nibble was also an escape reloads the generator to all ones. In an escape, escape, escape, '8' run, the final escape pair is therefore the one that sets the generator.
- R8: An escape followed by a code other than escape, 0100 or 1000 pulses err for one cycle, one cycle after the code nibble. The cell in progress delivers no further bytes.
- R9: A start-of-cell command that arrives while a cell is still being collected pulses short_cell one cycle after its second nibble, and the new cell restarts at byte 0.
- R10: A cycle with in_vld low changes no state, and no strobe is raised in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vld | input | 1 | Nibble present this cycle |
| in_esc | input | 1 | Nibble is the escape symbol |
| in_nib | input | 4 | Nibble value (ignored when in_esc is high) |
| out_vld | output | 1 | out_byte holds a cell byte |
| out_byte | output | 8 | Descrambled cell byte |
| out_first | output | 1 | Byte 0 of a cell |
| out_last | output | 1 | Byte 52 of a cell |
| marker | output | 1 | Timing marker seen |
| err | output | 1 | Unknown command code seen |
| short_cell | output | 1 | Previous cell aborted before completion |

## Verification
Every result is due exactly one cycle after the nibble that causes it. A byte follows its low nibble, and marker, err and short_cell follow the second nibble of their command. The bench drives a nibble on a falling edge and computes from its own model what must appear after the next rising edge. It compares all outputs on the following falling edge, so each check lands on the single cycle where the result is due. The bench scrambles a known plaintext with its own generator model and expects that plaintext back. Idle gaps, spliced markers and a triple-escape run then test the generator phase end to end.

// File: rtl/rxdsc_pkg.sv
// Package: shared constants, nibble classification type and the
// four-step generator advance for the receive descrambler.
// Assumes the generator polynomial x^10 + x^7 + 1 with bit k = X(t-k).
package rxdsc_pkg;

    localparam int GEN_W  = 10;
    localparam int NIB_W  = 4;
    localparam int BYTE_W = 2 * NIB_W;
    localparam int TAP_HI = GEN_W - 1;   // X(t-9)
    localparam int TAP_LO = GEN_W - 4;   // X(t-6)

    typedef enum logic [2:0] {
        K_NONE,      // no valid nibble
        K_OPEN,      // escape that opens a command
        K_DATA,      // ordinary data nibble
        K_SOC_RST,   // escape-escape
        K_SOC_KEEP,  // escape-keep code
        K_MARK,      // escape-marker code
        K_BAD        // escape-unknown code
    } nib_kind_t;

    // Advance the generator by one nibble (NIB_W new bits).
    function automatic logic [GEN_W-1:0] gen_adv(input logic [GEN_W-1:0] g);
        logic [GEN_W-1:0] r;
        r = g;
        for (int i = 0; i < NIB_W; i++) begin
            r = {r[GEN_W-2:0], r[TAP_HI] ^ r[TAP_LO]};
        end
        return r;
    endfunction

endpackage

// File: rtl/rx_descr_gen.sv
// Module: descrambling generator.
// Holds the 10-bit generator. It loads all ones on reload and otherwise
// advances four bits per valid nibble. mask gives the XOR pattern for the
// nibble currently presented. Assumes reload and step never call for
// anything but one of the two per cycle (reload wins).
module rx_descr_gen
    import rxdsc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             reload,
    output logic [NIB_W-1:0] mask,
    output logic [GEN_W-1:0] state
);

    logic [GEN_W-1:0] gen_q;

    // Generator register: reload to all ones, else advance one nibble.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_q <= '1;
        end else if (reload) begin
            gen_q <= '1;
        end else if (step) begin
            gen_q <= gen_adv(gen_q);
        end
    end

    assign mask  = gen_q[NIB_W-1:0];
    assign state = gen_q;

endmodule

// File: rtl/rx_cmd_parse.sv
// Module: command parser.
// Classifies each valid nibble as data, a command opener, or the second
// half of a command, and flags escapes that follow an escape (generator
// reload). Assumes escape pairs are counted from the start of the stream.
module rx_cmd_parse
    import rxdsc_pkg::*;
#(
    parameter logic [NIB_W-1:0] CODE_KEEP = 4'h4,
    parameter logic [NIB_W-1:0] CODE_MARK = 4'h8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    input  logic             in_esc,
    input  logic [NIB_W-1:0] in_nib,
    output nib_kind_t        kind,
    output logic             reload
);

    logic esc_pend_q;   // an escape is waiting for its partner
    logic prev_esc_q;   // last valid nibble was an escape

    // Pairing and history flags, updated only on valid nibbles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            esc_pend_q <= 1'b0;
            prev_esc_q <= 1'b0;
        end else if (in_vld) begin
            esc_pend_q <= !esc_pend_q && in_esc;
            prev_esc_q <= in_esc;
        end
    end

    // Classification of the current nibble.
    always_comb begin
        if (!in_vld) begin
            kind = K_NONE;
        end else if (esc_pend_q) begin
            if (in_esc)                  kind = K_SOC_RST;
            else if (in_nib == CODE_KEEP) kind = K_SOC_KEEP;
            else if (in_nib == CODE_MARK) kind = K_MARK;
            else                          kind = K_BAD;
        end else if (in_esc) begin
            kind = K_OPEN;
        end else begin
            kind = K_DATA;
        end
    end

    // Reload on an escape directly after an escape.
    assign reload = in_vld && in_esc && prev_esc_q;

endmodule

// File: rtl/rx_cell_pack.sv
// Module: cell packer.
// Tracks lock and cell progress, packs descrambled nibbles into bytes and
// raises the one-cycle event strobes. Every output is registered, one
// cycle after the nibble that causes it.
module rx_cell_pack
    import rxdsc_pkg::*;
#(
    parameter int CELL_BYTES = 53
) (
    input  logic              clk,
    input  logic              rst_n,
    input  nib_kind_t         kind,
    input  logic [NIB_W-1:0]  nib_clr,
    output logic              out_vld,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_first,
    output logic              out_last,
    output logic              marker,
    output logic              err,
    output logic              short_cell
);

    localparam int CNT_W = $clog2(CELL_BYTES + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CELL_BYTES - 1);

    logic             synced_q;
    logic             active_q;
    logic             half_q;
    logic [NIB_W-1:0] hi_q;
    logic [CNT_W-1:0] cnt_q;
    logic             soc;

    // A start-of-cell is honoured on escape-escape, or escape-keep once locked.
    assign soc = (kind == K_SOC_RST) || (kind == K_SOC_KEEP && synced_q);

    // Cell state, byte packing and event strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            synced_q   <= 1'b0;
            active_q   <= 1'b0;
            half_q     <= 1'b0;
            hi_q       <= '0;
            cnt_q      <= '0;
            out_vld    <= 1'b0;
            out_byte   <= '0;
            out_first  <= 1'b0;
            out_last   <= 1'b0;
            marker     <= 1'b0;
            err        <= 1'b0;
            short_cell <= 1'b0;
        end else begin
            out_vld    <= 1'b0;
            out_first  <= 1'b0;
            out_last   <= 1'b0;
            marker     <= 1'b0;
            err        <= 1'b0;
            short_cell <= 1'b0;
            if (kind == K_SOC_RST) begin
                synced_q <= 1'b1;
            end
            if (soc) begin
                short_cell <= active_q;
                active_q   <= 1'b1;
                cnt_q      <= '0;
                half_q     <= 1'b0;
            end else if (kind == K_MARK) begin
                marker <= 1'b1;
            end else if (kind == K_BAD) begin
                err      <= 1'b1;
                active_q <= 1'b0;
            end else if (kind == K_DATA && active_q) begin
                if (!half_q) begin
                    hi_q   <= nib_clr;
                    half_q <= 1'b1;
                end else begin
                    half_q    <= 1'b0;
                    out_vld   <= 1'b1;
                    out_byte  <= {hi_q, nib_clr};
                    out_first <= (cnt_q == '0);
                    out_last  <= (cnt_q == LAST_IDX);
                    cnt_q     <= cnt_q + 1'b1;
                    if (cnt_q == LAST_IDX) begin
                        active_q <= 1'b0;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/rx_cmd_descrambler.sv
// Module: receive command detector and descrambler (top).
// Takes tagged nibbles, decodes commands, keeps the descrambling
// generator locked through escape-escape and delivers cell bytes.
// Assumes the input is already symbol-decoded with the escape tagged.
module rx_cmd_descrambler
    import rxdsc_pkg::*;
#(
    parameter int               CELL_BYTES = 53,
    parameter logic [3:0]       CODE_KEEP  = 4'h4,
    parameter logic [3:0]       CODE_MARK  = 4'h8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_vld,
    input  logic       in_esc,
    input  logic [3:0] in_nib,
    output logic       out_vld,
    output logic [7:0] out_byte,
    output logic       out_first,
    output logic       out_last,
    output logic       marker,
    output logic       err,
    output logic       short_cell
);

    nib_kind_t        kind;
    logic             reload;
    logic [NIB_W-1:0] mask;
    logic [GEN_W-1:0] gen_state;
    logic [NIB_W-1:0] nib_clr;

    rx_cmd_parse #(
        .CODE_KEEP (CODE_KEEP),
        .CODE_MARK (CODE_MARK)
    ) parse_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_vld (in_vld),
        .in_esc (in_esc),
        .in_nib (in_nib),
        .kind   (kind),
        .reload (reload)
    );

    rx_descr_gen gen_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (in_vld),
        .reload (reload),
        .mask   (mask),
        .state  (gen_state)
    );

    // Descrambled value of the current nibble (used only for data).
    assign nib_clr = in_nib ^ mask;

    rx_cell_pack #(
        .CELL_BYTES (CELL_BYTES)
    ) pack_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .kind       (kind),
        .nib_clr    (nib_clr),
        .out_vld    (out_vld),
        .out_byte   (out_byte),
        .out_first  (out_first),
        .out_last   (out_last),
        .marker     (marker),
        .err        (err),
        .short_cell (short_cell)
    );

endmodule

// File: rtl/rx_cmd_descrambler_chk.sv
// Module: property checker bound to the top module.
module rx_cmd_descrambler_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_vld,
    input logic       out_vld,
    input logic       out_first,
    input logic       out_last,
    input logic       marker,
    input logic       err,
    input logic       short_cell,
    input logic [9:0] gen_state
);

    // R3: a maximal-length generator reloaded to all ones never reaches zero
    a_r3_gen_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        gen_state != 10'd0);

    // R4: cell boundary strobes only accompany a byte
    a_r4_first_with_byte: assert property (@(posedge clk) disable iff (!rst_n)
        out_first |-> out_vld);
    a_r4_last_with_byte: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_vld);

    // R6: a marker is a single-cycle pulse and carries no byte
    a_r6_marker_single: assert property (@(posedge clk) disable iff (!rst_n)
        marker |=> !marker);
    a_r6_marker_no_byte: assert property (@(posedge clk) disable iff (!rst_n)
        marker |-> !out_vld);

    // R8: an error is a single-cycle pulse
    a_r8_err_single: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);

    // R9: short and error never come from the same command
    a_r9_short_not_err: assert property (@(posedge clk) disable iff (!rst_n)
        short_cell |-> !err);

    // R10: an idle input cycle produces no strobe in the next cycle
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> (!out_vld && !marker && !err && !short_cell));

endmodule

bind rx_cmd_descrambler rx_cmd_descrambler_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_vld     (in_vld),
    .out_vld    (out_vld),
    .out_first  (out_first),
    .out_last   (out_last),
    .marker     (marker),
    .err        (err),
    .short_cell (short_cell),
    .gen_state  (gen_state)
);

// File: tb/rx_cmd_descrambler_tb_top.sv
// Bench: scrambles known plaintext with a behavioural transmit generator,
// predicts every output from a behavioural receiver model and compares
// on every clock.
module rx_cmd_descrambler_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_vld, in_esc;
    logic [3:0] in_nib;
    logic       out_vld, out_first, out_last, marker, err, short_cell;
    logic [7:0] out_byte;

    always #5 clk = ~clk;

    rx_cmd_descrambler dut_i (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_esc(in_esc),
        .in_nib(in_nib), .out_vld(out_vld), .out_byte(out_byte),
        .out_first(out_first), .out_last(out_last), .marker(marker),
        .err(err), .short_cell(short_cell)
    );

    int    checks = 0;
    int    fails  = 0;
    string req    = "R1";
    int    gap_ctr = 0;
    bit    gaps_on = 0;

    // transmit generator, index 0 is the newest bit X(t)
    bit txg[$];
    bit tx_prev_esc;

    // receiver model
    bit         m_synced, m_active, m_half, m_pend;
    int         m_cnt;
    logic [3:0] m_hi;

    // expectations for the next compare
    logic       e_vld, e_first, e_last, e_mark, e_err, e_short;
    logic [7:0] e_byte;

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    task automatic chk1(string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare_outs();
        chk1("out_vld (R4)", 8'(out_vld), 8'(e_vld));
        if (e_vld) begin
            chk1("out_byte (R3)", out_byte, e_byte);
            chk1("out_first (R4)", 8'(out_first), 8'(e_first));
            chk1("out_last (R4)", 8'(out_last), 8'(e_last));
        end
        chk1("marker (R6)", 8'(marker), 8'(e_mark));
        chk1("err (R8)", 8'(err), 8'(e_err));
        chk1("short_cell (R9)", 8'(short_cell), 8'(e_short));
    endtask

    task automatic start_cell();
        e_short  = m_active;
        m_active = 1;
        m_cnt    = 0;
        m_half   = 0;
    endtask

    // one cycle: compare previous results, drive a nibble, predict results
    task automatic step(bit v, bit esc, logic [3:0] val);
        logic [3:0] mask;
        @(negedge clk);
        compare_outs();
        {e_vld, e_first, e_last, e_mark, e_err, e_short} = '0;
        e_byte = '0;
        in_vld = v;
        in_esc = esc;
        if (!v) begin
            in_nib = 4'h0;
            return;
        end
        mask = {txg[3], txg[2], txg[1], txg[0]};
        if (esc)          in_nib = 4'h0;
        else if (m_pend)  in_nib = val;
        else              in_nib = val ^ mask;
        if (m_pend) begin
            m_pend = 0;
            if (esc) begin
                m_synced = 1;
                start_cell();
            end else if (val == 4'h4) begin
                if (m_synced) start_cell();
            end else if (val == 4'h8) begin
                e_mark = 1;
            end else begin
                e_err    = 1;
                m_active = 0;
            end
        end else if (esc) begin
            m_pend = 1;
        end else if (m_active) begin
            if (!m_half) begin
                m_hi   = val;
                m_half = 1;
            end else begin
                m_half  = 0;
                e_vld   = 1;
                e_byte  = {m_hi, val};
                e_first = (m_cnt == 0);
                e_last  = (m_cnt == 52);
                m_cnt++;
                if (m_cnt == 53) m_active = 0;
            end
        end
        if (esc && tx_prev_esc) begin
            foreach (txg[i]) txg[i] = 1'b1;
        end else begin
            for (int k = 0; k < 4; k++) begin
                bit nb;
                nb = txg[9] ^ txg[6];
                txg.push_front(nb);
                void'(txg.pop_back());
            end
        end
        tx_prev_esc = esc;
    endtask

    task automatic send_nib(bit esc, logic [3:0] val);
        if (gaps_on && (gap_ctr % 7 == 6)) step(0, 0, 4'h0);
        gap_ctr++;
        step(1, esc, val);
    endtask

    task automatic send_byte(logic [7:0] b);
        send_nib(0, b[7:4]);
        send_nib(0, b[3:0]);
    endtask

    task automatic send_cmd(bit second_esc, logic [3:0] code);
        send_nib(1, 4'h0);
        send_nib(second_esc, code);
    endtask

    task automatic send_bytes(int n, int seed);
        for (int i = 0; i < n; i++) send_byte(8'((seed + i * 37) & 255));
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 10; i++) txg.push_back(1'b1);
        tx_prev_esc = 0;
        {m_synced, m_active, m_half, m_pend} = '0;
        m_cnt = 0;
        m_hi  = '0;
        {e_vld, e_first, e_last, e_mark, e_err, e_short} = '0;
        e_byte = '0;
        rst_n  = 1'b0;
        in_vld = 1'b0;
        in_esc = 1'b0;
        in_nib = 4'h0;
        // R1: reset state
        req = "R1";
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare_outs();
        rst_n = 1'b1;

        // R1: data and escape-keep before lock deliver nothing
        send_bytes(4, 5);
        send_cmd(0, 4'h4);
        send_bytes(3, 9);

        // R2 R3 R4: locked cell, then extra data after byte 52 discarded
        req = "R2";
        send_cmd(1, 4'h0);
        req = "R3";
        send_bytes(53, 17);
        req = "R4";
        send_bytes(3, 200);

        // R5 R10: keep-phase cell with idle gaps
        req = "R5";
        gaps_on = 1;
        send_cmd(0, 4'h4);
        send_bytes(53, 99);

        // R6: marker spliced into a cell
        req = "R6";
        send_cmd(0, 4'h4);
        send_bytes(10, 3);
        send_cmd(0, 4'h8);
        send_bytes(43, 77);
        gaps_on = 0;

        // R7: escape, escape, escape, marker run then cell data
        req = "R7";
        send_cmd(1, 4'h0);
        send_cmd(0, 4'h8);
        send_bytes(53, 41);

        // R8: unknown command code drops the cell
        req = "R8";
        send_cmd(0, 4'h4);
        send_bytes(5, 61);
        send_cmd(0, 4'h3);
        send_bytes(6, 8);

        // R9: start-of-cell during a cell flags it short and restarts
        req = "R9";
        send_cmd(1, 4'h0);
        send_bytes(20, 13);
        send_cmd(0, 4'h4);
        send_bytes(53, 29);

        // R10: idle cycles produce nothing
        req = "R10";
        for (int i = 0; i < 4; i++) step(0, 0, 4'h0);
        step(0, 0, 4'h0);

        summary();
        $finish;
    end

endmodule